// File: doc/BRIEF.md
# SD SPI Block Read Engine

This engine collects one or more data blocks from a memory card running in SPI mode, once the read command has already been accepted by the card. It sits on a byte-level SPI master: it raises a one-cycle request for each byte, always sending all-ones on the serial output, and takes the received byte when the master acknowledges. On the host side it takes a block count, a block size, a CRC-check enable and a start strobe. Every payload byte it receives is passed on through a valid/data pair. When it has finished it raises done together with at most one error flag.

For each block the engine first searches for the start token 0xFE, reading filler bytes up to a limit that is set by a parameter. It then reads exactly block-size payload bytes and two CRC bytes, high byte first. While the payload streams in, it computes a CRC16-CCITT (polynomial 0x1021, initial value 0) one byte per clock. It repeats these steps until the block count reaches zero, or it stops early on a timeout or a CRC mismatch. To read a 16-byte card register, use the same path with a count of 1 and a size of 16.

The states are ST_IDLE, ST_HUNT, ST_PAYLOAD, ST_CRC_HI, ST_CRC_LO and ST_FINISH. The transitions are:
- ST_IDLE to ST_HUNT on start with a nonzero count, or ST_IDLE to ST_FINISH on start with a zero count.
- ST_HUNT to ST_PAYLOAD on the token, or ST_HUNT to ST_FINISH on the limit.
- ST_PAYLOAD to ST_CRC_HI on the last payload byte.
- ST_CRC_HI to ST_CRC_LO on the next byte.
- ST_CRC_LO to ST_FINISH on a mismatch or on the last block, or ST_CRC_LO to ST_HUNT for the next block.
- ST_FINISH to ST_IDLE unconditionally.

Top module: `sdrd_block_reader`

## Requirements
- R1: After reset the engine is idle: byte_req, rd_valid, busy, done, crc_err and tmo_err are all 0.
- R2: Every byte request drives byte_tx = 0xFF, and only one request is outstanding at a time: no new byte_req is raised until byte_ack has returned the previous byte.
- R3: While the engine searches for a token, every received byte other than 0xFE is discarded and never shown on rd_valid. The first 0xFE starts the payload, and the engine issues no requests beyond the bytes that the blocks need.
- R4: If TOKEN_LIMIT consecutive non-token bytes arrive while the engine searches for a block's token, it ends with done and tmo_err = 1 and issues no further requests. A token that arrives as byte TOKEN_LIMIT-1 or earlier is accepted, and the byte count restarts for every block.
- R5: Each block delivers exactly blk_size payload bytes, in arrival order, on rd_data. rd_valid is high in the cycle after the byte_ack that carried the byte. Payload bytes equal to 0xFE are data, not tokens.
- R6: With crc_check_en = 1, the two bytes after the payload form the expected CRC, high byte first. The expected value is CRC16-CCITT with polynomial 0x1021, initial value 0, processed MSB first (for the ASCII digits "123456789" it is 0x31C3). On a mismatch the engine ends with done and crc_err = 1 and reads no further blocks.
- R7: With crc_check_en = 0, the two CRC bytes are read and discarded, and crc_err stays 0.
- R8: Blocks repeat until blk_count have been read. done is a single-cycle pulse, and on success it comes with crc_err = tmo_err = 0.
- R9: A start with blk_count = 0 raises done in the cycle after start, with no byte request and no error flag.
- R10: A start pulse while the engine is busy is ignored.
- R11: busy is high from the cycle after an accepted start until done. crc_err and tmo_err hold their value after done, and the next accepted start clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start strobe, accepted only when idle |
| blk_count | input | CNT_W | Number of blocks to read |
| blk_size | input | SIZE_W | Payload bytes per block, nonzero |
| crc_check_en | input | 1 | Compare the received CRC with the computed one |
| byte_req | output | 1 | One-cycle request to clock one byte |
| byte_tx | output | 8 | Byte to transmit, always 0xFF |
| byte_ack | input | 1 | Master returns the received byte |
| byte_rx | input | 8 | Received byte, valid with byte_ack |
| rd_valid | output | 1 | Payload byte strobe |
| rd_data | output | 8 | Payload byte |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle end-of-read pulse |
| crc_err | output | 1 | Read ended on a CRC mismatch |
| tmo_err | output | 1 | Read ended on a token search timeout |

## Verification
Each result has a fixed time after the stimulus that causes it:
- busy rises, and a zero-count done appears, in the cycle after the start edge.
- A payload byte appears on rd_valid in the cycle after its byte_ack.
- done and its error flag appear in the cycle after the acknowledge of the final CRC byte or the final timed-out search byte.

The bench drives the byte master from falling edges and samples every output on falling edges, so each value it reads has settled after the rising edge that produced it. It waits for done within a bounded loop, compares byte counts, request counts and payload contents against a stream it built itself, and checks that done has dropped one cycle later.

// File: rtl/sdrd_pkg.sv
package sdrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_PAYLOAD,
        ST_CRC_HI,
        ST_CRC_LO,
        ST_FINISH
    } rd_state_e;

    localparam logic [7:0]  START_TOKEN = 8'hFE;
    localparam logic [7:0]  FILL_BYTE   = 8'hFF;
    localparam logic [15:0] CRC_POLY    = 16'h1021;

    // Folds one byte, MSB first, into a CRC16 with polynomial CRC_POLY.
    function automatic logic [15:0] crc_next(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ d[i];
            r  = {r[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
        end
        return r;
    endfunction

endpackage

// File: rtl/sdrd_crc16.sv
module sdrd_crc16
    import sdrd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] crc_o
);

    logic [15:0] crc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= 16'h0000;
        end else if (clr) begin
            crc_q <= 16'h0000;
        end else if (upd) begin
            crc_q <= crc_next(crc_q, din);
        end
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/sdrd_cnt.sv
module sdrd_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/sdrd_block_reader.sv
module sdrd_block_reader
    import sdrd_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SIZE_W      = 12,
    parameter int TOKEN_LIMIT = 3000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  blk_count,
    input  logic [SIZE_W-1:0] blk_size,
    input  logic              crc_check_en,
    output logic              byte_req,
    output logic [7:0]        byte_tx,
    input  logic              byte_ack,
    input  logic [7:0]        byte_rx,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              done,
    output logic              crc_err,
    output logic              tmo_err
);

    localparam int              HUNT_W   = $clog2(TOKEN_LIMIT + 1);
    localparam logic [HUNT_W-1:0] HUNT_MAX = HUNT_W'(TOKEN_LIMIT - 1);

    rd_state_e         state_q, state_d;
    logic              pending_q;
    logic [CNT_W-1:0]  blocks_left_q;
    logic [SIZE_W-1:0] size_q;
    logic              crcen_q;
    logic [7:0]        crc_hi_q;
    logic              crc_err_q, tmo_err_q;
    logic              rd_valid_q;
    logic [7:0]        rd_data_q;

    logic [HUNT_W-1:0] hunt_cnt;
    logic [SIZE_W-1:0] pay_cnt;
    logic [15:0]       crc_val;

    logic accept, is_token, hunt_last, pay_last, crc_bad, last_block, req_int;

    assign accept     = pending_q && byte_ack;
    assign is_token   = (byte_rx == START_TOKEN);
    assign hunt_last  = (hunt_cnt == HUNT_MAX);
    assign pay_last   = (pay_cnt == size_q - 1'b1);
    assign crc_bad    = crcen_q && ({crc_hi_q, byte_rx} != crc_val);
    assign last_block = (blocks_left_q == {{(CNT_W-1){1'b0}}, 1'b1});

    sdrd_cnt #(.W(HUNT_W)) u_hunt_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_HUNT),
        .inc   (accept && (state_q == ST_HUNT) && !is_token),
        .cnt_o (hunt_cnt)
    );

    sdrd_cnt #(.W(SIZE_W)) u_pay_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q != ST_PAYLOAD),
        .inc   (accept && (state_q == ST_PAYLOAD)),
        .cnt_o (pay_cnt)
    );

    sdrd_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == ST_HUNT),
        .upd   (accept && (state_q == ST_PAYLOAD)),
        .din   (byte_rx),
        .crc_o (crc_val)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (blk_count == '0) ? ST_FINISH : ST_HUNT;
                end
            end
            ST_HUNT: begin
                if (accept) begin
                    if (is_token)       state_d = ST_PAYLOAD;
                    else if (hunt_last) state_d = ST_FINISH;
                end
            end
            ST_PAYLOAD: begin
                if (accept && pay_last) state_d = ST_CRC_HI;
            end
            ST_CRC_HI: begin
                if (accept) state_d = ST_CRC_LO;
            end
            ST_CRC_LO: begin
                if (accept) begin
                    if (crc_bad || last_block) state_d = ST_FINISH;
                    else                       state_d = ST_HUNT;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register and per-read datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            pending_q     <= 1'b0;
            blocks_left_q <= '0;
            size_q        <= '0;
            crcen_q       <= 1'b0;
            crc_hi_q      <= 8'h00;
            crc_err_q     <= 1'b0;
            tmo_err_q     <= 1'b0;
            rd_valid_q    <= 1'b0;
            rd_data_q     <= 8'h00;
        end else begin
            state_q    <= state_d;
            rd_valid_q <= accept && (state_q == ST_PAYLOAD);
            if (req_int)     pending_q <= 1'b1;
            else if (accept) pending_q <= 1'b0;
            if (accept && (state_q == ST_PAYLOAD)) rd_data_q <= byte_rx;
            if (accept && (state_q == ST_CRC_HI))  crc_hi_q  <= byte_rx;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        blocks_left_q <= blk_count;
                        size_q        <= blk_size;
                        crcen_q       <= crc_check_en;
                        crc_err_q     <= 1'b0;
                        tmo_err_q     <= 1'b0;
                    end
                end
                ST_HUNT: begin
                    if (accept && !is_token && hunt_last) tmo_err_q <= 1'b1;
                end
                ST_CRC_LO: begin
                    if (accept) begin
                        blocks_left_q <= blocks_left_q - 1'b1;
                        if (crc_bad) crc_err_q <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_int = 1'b0;
        unique case (state_q)
            ST_HUNT, ST_PAYLOAD, ST_CRC_HI, ST_CRC_LO: req_int = !pending_q;
            default:                                   req_int = 1'b0;
        endcase
        byte_req = req_int;
        byte_tx  = FILL_BYTE;
        busy     = (state_q != ST_IDLE) && (state_q != ST_FINISH);
        done     = (state_q == ST_FINISH);
        crc_err  = crc_err_q;
        tmo_err  = tmo_err_q;
        rd_valid = rd_valid_q;
        rd_data  = rd_data_q;
    end

    // R2: a request is never followed by another in the next cycle
    a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |=> !byte_req);

    // R8: done lasts a single cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4 / R6: at most one error cause is reported
    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(crc_err && tmo_err));

    // R5: a payload strobe always follows an acknowledge
    a_r5_valid_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(byte_ack));

    // R9: zero count finishes immediately
    a_r9_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && (blk_count == '0)) |=> (done && !byte_req));

    // R11: accepted start with blocks to read raises busy
    a_r11_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done && (blk_count != '0)) |=> busy);

    // R4: no requests once finished
    a_r4_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !byte_req);

endmodule

// File: tb/sim_sdrd_block_reader.sv
`timescale 1ns/1ps
module sim_sdrd_block_reader;

    localparam int LIMIT  = 20;
    localparam int CNT_W  = 16;
    localparam int SIZE_W = 12;

    // {cnt[31:28], size[27:20], crcen[19:16], junk[15:8], bad_blk[7:4] (F=none), result[3:0] 0=ok 1=crc 2=tmo}
    localparam logic [31:0] VEC [0:7] = '{
        32'h1101_03F0,
        32'h3051_00F0,
        32'h4071_0211,
        32'h2040_0100,
        32'h2011_13F0,
        32'h1081_14F2,
        32'h3031_0521,
        32'h1FF1_00F0
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  blk_count = '0;
    logic [SIZE_W-1:0] blk_size = '0;
    logic              crc_check_en = 1'b0;
    logic              byte_req;
    logic [7:0]        byte_tx;
    logic              byte_ack;
    logic [7:0]        byte_rx;
    logic              rd_valid;
    logic [7:0]        rd_data;
    logic              busy, done, crc_err, tmo_err;

    sdrd_block_reader #(.CNT_W(CNT_W), .SIZE_W(SIZE_W), .TOKEN_LIMIT(LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_count(blk_count),
        .blk_size(blk_size), .crc_check_en(crc_check_en),
        .byte_req(byte_req), .byte_tx(byte_tx), .byte_ack(byte_ack), .byte_rx(byte_rx),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .done(done),
        .crc_err(crc_err), .tmo_err(tmo_err)
    );

    always #2.5 clk = ~clk;

    int nchk = 0, nfail = 0;
    bit finished = 0;

    logic [7:0] card [0:4095];
    logic [7:0] expb [0:4095];
    logic [7:0] got  [0:4095];
    int clen = 0, ptr = 0, nreq = 0, nexp = 0, nbytes = 0, ndone = 0, tx_bad = 0;

    // Byte master and card model
    initial begin
        byte_ack = 1'b0;
        byte_rx  = 8'h00;
        forever begin
            @(negedge clk);
            byte_ack = 1'b0;
            if (byte_req) begin
                if (byte_tx != 8'hFF) tx_bad++;
                @(negedge clk);
                byte_ack = 1'b1;
                byte_rx  = (ptr < clen) ? card[ptr] : 8'hFF;
                ptr++;
                nreq++;
            end
        end
    end

    // Output collector
    always @(negedge clk) begin
        if (rd_valid) begin
            if (nbytes < 4096) got[nbytes] = rd_data;
            nbytes++;
        end
        if (done) ndone++;
    end

    task automatic chk(input string tag, input int act, input int expv);
        nchk++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] x;
        x = c ^ {d, 8'h00};
        for (int i = 0; i < 8; i++) x = x[15] ? ((x << 1) ^ 16'h1021) : (x << 1);
        return x;
    endfunction

    task automatic build(input int cnt, input int size, input int junk, input int bad, input int seed);
        logic [15:0] c;
        logic [7:0]  v;
        clen = 0;
        nexp = 0;
        for (int b = 0; b < cnt; b++) begin
            for (int j = 0; j < junk; j++) begin
                card[clen] = (j % 2 == 1) ? 8'hFF : 8'h1F;
                clen++;
            end
            card[clen] = 8'hFE;
            clen++;
            c = 16'h0000;
            for (int k = 0; k < size; k++) begin
                v = 8'(seed * 37 + b * 59 + k * 13 + 5);
                card[clen] = v;
                clen++;
                expb[nexp] = v;
                nexp++;
                c = ref_crc(c, v);
            end
            if (b == bad) c = c ^ 16'h0100;
            card[clen] = c[15:8];
            clen++;
            card[clen] = c[7:0];
            clen++;
        end
    endtask

    task automatic launch(input int cnt, input int size, input bit crcen);
        @(negedge clk);
        ptr = 0; nreq = 0; nbytes = 0; ndone = 0; tx_bad = 0;
        blk_count    = CNT_W'(cnt);
        blk_size     = SIZE_W'(size);
        crc_check_en = crcen;
        start        = 1'b1;
        @(negedge clk);
        start        = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        int t;
        t = 0;
        while (!done && t < 4000) begin
            @(negedge clk);
            t++;
        end
        seen = done;
    endtask

    initial begin
        bit seen;
        int cnt, size, junk, bad, res, plen, eb, er;
        int mism;
        logic [15:0] kc;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 byte_req", byte_req, 0);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 flags", {crc_err, tmo_err}, 0);
        chk("R1 rd_valid", rd_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < 8; v++) begin
            cnt  = int'(VEC[v][31:28]);
            size = int'(VEC[v][27:20]);
            junk = int'(VEC[v][15:8]);
            bad  = (VEC[v][7:4] == 4'hF) ? -1 : int'(VEC[v][7:4]);
            res  = int'(VEC[v][3:0]);
            build(cnt, size, junk, bad, v);
            launch(cnt, size, VEC[v][16]);
            chk("R11 busy after start", busy, 1);
            wait_done(seen);
            chk("R8 done reached", seen, 1);
            plen = junk + 1 + size + 2;
            eb = (res == 0) ? cnt * size : (res == 1) ? (bad + 1) * size : 0;
            er = (res == 0) ? cnt * plen : (res == 1) ? (bad + 1) * plen : LIMIT;
            chk("R6 crc_err", crc_err, (res == 1) ? 1 : 0);
            chk("R4 tmo_err", tmo_err, (res == 2) ? 1 : 0);
            @(negedge clk);
            chk("R8 done single cycle", done, 0);
            repeat (12) @(negedge clk);
            chk("R5 payload count", nbytes, eb);
            chk("R3 request count", nreq, er);
            chk("R2 fill byte", tx_bad, 0);
            mism = 0;
            for (int i = 0; i < eb && i < nbytes; i++) if (got[i] != expb[i]) mism++;
            chk("R5 payload contents", mism, 0);
        end

        // R11: flags hold after done, then clear on next start
        build(1, 4, LIMIT, -1, 11);
        launch(1, 4, 1'b1);
        wait_done(seen);
        repeat (10) @(negedge clk);
        chk("R11 tmo_err holds", tmo_err, 1);
        chk("R4 idle after timeout", busy, 0);
        build(1, 4, 0, -1, 12);
        launch(1, 4, 1'b1);
        chk("R11 flag cleared by start", tmo_err, 0);
        wait_done(seen);
        chk("R8 ok done", {crc_err, tmo_err}, 0);

        // R9: zero count
        repeat (3) @(negedge clk);
        launch(0, 4, 1'b1);
        chk("R9 done after start", done, 1);
        repeat (8) @(negedge clk);
        chk("R9 no request", nreq, 0);
        chk("R9 no flags", {crc_err, tmo_err}, 0);

        // R10: start while busy is ignored
        build(3, 4, 0, -1, 13);
        launch(1, 4, 1'b1);
        @(negedge clk);
        blk_count = CNT_W'(3);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(seen);
        repeat (40) @(negedge clk);
        chk("R10 bytes", nbytes, 4);
        chk("R10 done pulses", ndone, 1);
        chk("R10 requests", nreq, 7);

        // R6: known CRC value of the ASCII digits
        kc = 16'h0000;
        clen = 0;
        card[clen] = 8'hFE; clen++;
        for (int i = 0; i < 9; i++) begin
            card[clen] = 8'h31 + 8'(i);
            expb[i] = 8'h31 + 8'(i);
            kc = ref_crc(kc, 8'h31 + 8'(i));
            clen++;
        end
        chk("R6 reference crc", kc, 16'h31C3);
        card[clen] = 8'h31; clen++;
        card[clen] = 8'hC3; clen++;
        launch(1, 9, 1'b1);
        wait_done(seen);
        chk("R6 known crc accepted", crc_err, 0);
        repeat (4) @(negedge clk);
        chk("R6 known payload count", nbytes, 9);
        // R7: same stream with a wrong CRC and checking off
        card[clen-1] = 8'h00;
        launch(1, 9, 1'b0);
        wait_done(seen);
        chk("R7 crc ignored", crc_err, 0);
        // R6: same wrong CRC with checking on
        launch(1, 9, 1'b1);
        wait_done(seen);
        chk("R6 wrong crc flagged", crc_err, 1);

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule